// File: doc/BRIEF.md
# Light-Load Sense Mode Controller

This block holds, for every channel of a high-side switch, the small state machine that decides when the channel runs in its light-load current-sense mode. In that mode the gate driver uses only part of the power device, and the sense path switches to its high-gain setting. Software asks for the mode by writing an enable bit. The request is granted only when the entry comparator reports that the load current is below the entry level at the moment of the write.

Once the mode is granted, hardware watches the exit comparator on every clock. When the load current climbs above the exit level, the channel drops back to the full device in that same cycle, and the enable bit clears itself. After that, software has to write the bit again; a later fall in current alone never brings the mode back. Software can also leave the mode at any time by writing 0. Turning the channel off forces normal mode.

The readable status bit always reflects the live mode. Software should check it before trusting a high-gain current reading. All pins are plain level-sensitive control and status signals, one bit per channel. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `lcs_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, every channel's status bit and select output are 0.
- R2: A write of 1 on a channel that is on, with the entry comparator high in that cycle, sets the status bit and select output to 1 from the next cycle.
- R3: A write of 1 while the entry comparator is low leaves a channel that is in normal mode at 0. A write of 1 to a channel already in the mode keeps it in the mode whatever the entry comparator shows.
- R4: While a channel is in the mode, an exit comparator high drives its status and select to 0 in that same cycle, and they stay 0 afterwards.
- R5: After an automatic exit, the entry comparator going high without a new write of 1 does not restore the mode.
- R6: A write of 0 returns the channel to normal mode; status reads 0 from the next cycle.
- R7: With the channel off, status and select are 0 in that same cycle. A write of 1 is ignored, and the mode stays cleared when the channel turns back on.
- R8: A write of 1 in the same cycle as an exit event loses to the exit: the channel is in normal mode on the next cycle.
- R9: Channels are independent: stimulus on one channel never changes another channel's status.
- R10: The select output equals the status bit on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | NUM_CH | Software write strobe for each channel's enable bit |
| sw_wdata | input | NUM_CH | Value written with the strobe (1 request, 0 leave) |
| cur_below_entry | input | NUM_CH | High when the channel current is below the entry level |
| cur_above_exit | input | NUM_CH | High when the channel current is above the exit level |
| chan_on | input | NUM_CH | High when the channel output is commanded on |
| mode_stat | output | NUM_CH | Readable live state of the enable bit |
| light_sel | output | NUM_CH | Select to use the partial device and the high-gain sense setting |

## Verification
A stuck or stale mode register shows up at the ports on the very next cycle as a status bit that disagrees with the last write, exit or channel-off event. A missing combinational exit path shows up in the exit cycle itself, when select stays high while the exit comparator is high. A wrong priority between a write and an exit is visible one cycle after the collision. Because every state and input combination is swept from both starting states, each wrong transition shows within two cycles of its stimulus.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic {
    LCS_NORMAL = 1'b0,
    LCS_LIGHT  = 1'b1
  } lcs_state_e;

  typedef struct packed {
    logic wr;
    logic wdata;
    logic below_entry;
    logic above_exit;
    logic on;
  } lcs_in_t;
endpackage

// File: rtl/lcs_next.sv
module lcs_next
  import lcs_pkg::*;
(
  input  lcs_state_e cur,
  input  lcs_in_t    in,
  output lcs_state_e nxt,
  output logic       live
);
  logic exit_evt;

  always_comb begin
    exit_evt = (cur == LCS_LIGHT) && in.above_exit;
    live     = (cur == LCS_LIGHT) && in.on && !in.above_exit;
    if (!in.on) begin
      nxt = LCS_NORMAL;
    end else if (exit_evt) begin
      nxt = LCS_NORMAL;
    end else if (in.wr && !in.wdata) begin
      nxt = LCS_NORMAL;
    end else if (in.wr && in.wdata && in.below_entry) begin
      nxt = LCS_LIGHT;
    end else begin
      nxt = cur;
    end
  end
endmodule

// File: rtl/lcs_channel.sv
module lcs_channel
  import lcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  lcs_in_t in,
  output logic    stat,
  output logic    sel
);
  lcs_state_e state_q;
  lcs_state_e state_d;
  logic       live;

  lcs_next u_next (
    .cur  (state_q),
    .in   (in),
    .nxt  (state_d),
    .live (live)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LCS_NORMAL;
    else        state_q <= state_d;
  end

  assign stat = live;
  assign sel  = live;
endmodule

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
  import lcs_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sw_wr,
  input  logic [NUM_CH-1:0] sw_wdata,
  input  logic [NUM_CH-1:0] cur_below_entry,
  input  logic [NUM_CH-1:0] cur_above_exit,
  input  logic [NUM_CH-1:0] chan_on,
  output logic [NUM_CH-1:0] mode_stat,
  output logic [NUM_CH-1:0] light_sel
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lcs_in_t ch_in;
    assign ch_in = '{wr:          sw_wr[g],
                     wdata:       sw_wdata[g],
                     below_entry: cur_below_entry[g],
                     above_exit:  cur_above_exit[g],
                     on:          chan_on[g]};
    lcs_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .in    (ch_in),
      .stat  (mode_stat[g]),
      .sel   (light_sel[g])
    );
  end
endmodule

// File: rtl/lcs_ctrl_checker.sv
module lcs_ctrl_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] sw_wr,
  input logic [NUM_CH-1:0] sw_wdata,
  input logic [NUM_CH-1:0] cur_below_entry,
  input logic [NUM_CH-1:0] cur_above_exit,
  input logic [NUM_CH-1:0] chan_on,
  input logic [NUM_CH-1:0] mode_stat,
  input logic [NUM_CH-1:0] light_sel
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_EXIT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_above_exit[g] |-> !light_sel[g]); // R4
    AST_OFF_IS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_on[g] |-> !mode_stat[g]); // R7
    AST_ENTRY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_stat[g]) |-> $past(sw_wr[g] && sw_wdata[g] && cur_below_entry[g])); // R5
    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr[g] && !sw_wdata[g]) |=> !mode_stat[g]); // R6
    AST_EXIT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat[g] == 1'b0 && cur_above_exit[g] && $past(mode_stat[g]) && chan_on[g])
        |=> !mode_stat[g]); // R8
    AST_SEL_TRACKS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      light_sel[g] == mode_stat[g]); // R10
  end
endmodule

bind lcs_ctrl lcs_ctrl_checker #(.NUM_CH(NUM_CH)) u_lcs_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sw_wr           (sw_wr),
  .sw_wdata        (sw_wdata),
  .cur_below_entry (cur_below_entry),
  .cur_above_exit  (cur_above_exit),
  .chan_on         (chan_on),
  .mode_stat       (mode_stat),
  .light_sel       (light_sel)
);

// File: tb/lcs_ctrl_bench.sv
module lcs_ctrl_bench;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] sw_wr = '0;
  logic [NCH-1:0] sw_wdata = '0;
  logic [NCH-1:0] cur_below_entry = '0;
  logic [NCH-1:0] cur_above_exit = '0;
  logic [NCH-1:0] chan_on = '1;
  logic [NCH-1:0] mode_stat;
  logic [NCH-1:0] light_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcs_ctrl #(.NUM_CH(NCH)) u_lcs_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .sw_wr           (sw_wr),
    .sw_wdata        (sw_wdata),
    .cur_below_entry (cur_below_entry),
    .cur_above_exit  (cur_above_exit),
    .chan_on         (chan_on),
    .mode_stat       (mode_stat),
    .light_sel       (light_sel)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    sw_wr = '0; sw_wdata = '0; cur_below_entry = '0;
    cur_above_exit = '0; chan_on = '1;
  endtask

  task automatic drive(input int ch, input bit we, input bit wd,
                       input bit be, input bit ae, input bit on);
    idle();
    sw_wr[ch] = we; sw_wdata[ch] = wd; cur_below_entry[ch] = be;
    cur_above_exit[ch] = ae; chan_on[ch] = on;
  endtask

  task automatic set_state(input int ch, input bit st);
    @(negedge clk);
    drive(ch, 1'b1, st, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #1;
    for (int c = 0; c < NCH; c++) chk("R1 in reset", mode_stat[c], 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int c = 0; c < NCH; c++) begin
      chk("R1 after reset stat", mode_stat[c], 1'b0);
      chk("R1 after reset sel", light_sel[c], 1'b0);
    end

    for (int ch = 0; ch < NCH; ch++) begin
      for (int st = 0; st < 2; st++) begin
        for (int code = 0; code < 32; code++) begin
          automatic int oth = (ch + 1) % NCH;
          automatic bit we = code[0];
          automatic bit wd = code[1];
          automatic bit be = code[2];
          automatic bit ae = code[3];
          automatic bit on = code[4];
          automatic bit s  = st[0];
          automatic bit now_exp = s & on & ~ae;
          automatic bit nxt;
          automatic string tag;
          if (!on) nxt = 1'b0;
          else if (s && ae) nxt = 1'b0;
          else if (we && !wd) nxt = 1'b0;
          else if (we && wd && be) nxt = 1'b1;
          else nxt = s;
          if (!on) tag = "R7";
          else if (s && ae && we && wd) tag = "R8";
          else if (s && ae) tag = "R4";
          else if (we && !wd) tag = "R6";
          else if (we && wd && be) tag = "R2";
          else if (we && wd) tag = "R3";
          else tag = "R10";
          set_state(oth, ~s);
          set_state(ch, s);
          @(negedge clk);
          drive(ch, we, wd, be, ae, on);
          #1;
          chk({tag, " same cycle stat"}, mode_stat[ch], now_exp);
          chk({tag, " same cycle sel R10"}, light_sel[ch], now_exp);
          chk("R9 other channel", mode_stat[oth], ~s);
          @(negedge clk);
          idle();
          #1;
          chk({tag, " next cycle stat"}, mode_stat[ch], nxt);
          chk({tag, " next cycle sel R10"}, light_sel[ch], nxt);
          chk("R9 other channel next", mode_stat[oth], ~s);
        end
      end
    end

    set_state(0, 1'b1);
    #1 chk("R2 directed entry", mode_stat[0], 1'b1);
    @(negedge clk);
    drive(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    #1 chk("R4 directed exit", mode_stat[0], 1'b0);
    @(negedge clk);
    drive(0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    #1 chk("R5 no reentry on below", mode_stat[0], 1'b0);
    @(negedge clk);
    drive(0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    #1 chk("R5 still normal", mode_stat[0], 1'b0);
    @(negedge clk);
    drive(0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    idle();
    #1 chk("R5 reentry after new write", mode_stat[0], 1'b1);
    @(negedge clk);
    drive(0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    idle();
    #1 chk("R7 cleared after channel back on", mode_stat[0], 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule